// File: doc/BRIEF.md
# Power-Managed Clock Source Controller

This block picks the clock that drives a small microcontroller once it enters a power-managed mode. There are three candidates: a primary clock, a secondary low-speed oscillator, and an internal oscillator block. The internal block produces 8 MHz and a binary ladder of slower rates taken from it. It also has a separate 31 kHz low-power source. Each source is given to the block as a one-cycle clock-enable strobe, `*_tick`, in the 8 MHz control domain, together with a ready flag. The block sends one gated strobe to the CPU and one to the peripherals.

Software writes a source select field, a frequency select field and an idle-enable bit, all in the same write. A new source select value waits until a sleep request commits it. A new frequency select value acts on the next cycle. A source switch goes through a fixed state sequence: RUN, then DROP, then WAIT, then back to RUN. After the DROP cycle, ticks stay off until the new source reports ready. The state machine has three states:

- WAIT: no ticks; waits for the active source to be ready.
- DROP: one dead cycle after a new source is committed.
- RUN: ticks pass through.

The transitions are:

- reset to WAIT
- WAIT to RUN when the active source is ready
- RUN to DROP on an accepted sleep request that changes the source
- DROP to WAIT unconditionally

Top module: `pm_clk_ctrl`

## Requirements
- R1: After reset, the source select field is 00, the frequency field is 000, the active source is primary (`active_src` = 00), and the block is not in power-managed mode.
- R2: The source select encoding is 00 = primary, 01 = secondary, 10 or 11 = internal block. `active_src` reports 00, 01 or 10. The committed source drives the ticks.
- R3: Writing the source select field has no effect on `active_src`, the ticks or the status bits until a sleep request is accepted. A sleep request is accepted only in RUN.
- R4: When an accepted sleep request changes the source, `active_src` updates on the next cycle. This is followed by one DROP cycle with no ticks. Ticks then stay off in WAIT until the new source's ready flag is high.
- R5: With the internal block active, frequency code 111 ticks every cycle. Code k, for k from 1 to 6, ticks every 2^(7-k) cycles. Code 000 follows `lf_tick`, and in that case the internal source counts as ready whatever `int_rdy` is.
- R6: A write to the frequency field changes the internal tick rate from the next cycle, without a sleep request.
- R7: `stat_pri`, `stat_sec` and `stat_int` are each high only in RUN, with their own source active and ready. `stat_int` also requires a frequency code other than 000. At most one of the three is set.
- R8: All three status bits are clear when the internal block runs from the 31 kHz source, and also when the internal block is selected but `int_rdy` is low.
- R9: A sleep request that selects the secondary source while `sec_osc_en` is low keeps the current source.
- R10: An accepted sleep request enters power-managed mode, and `cpu_tick` stops. If idle-enable is set, `per_tick` keeps running; if it is clear, `per_tick` stops too. `wake_req` leaves power-managed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz control clock (internal block base) |
| rst_n | input | 1 | active-low reset |
| wr_en | input | 1 | write strobe for the control fields |
| wr_src | input | 2 | source select value to write |
| wr_freq | input | 3 | frequency select value to write |
| wr_idle | input | 1 | idle-enable value to write |
| sec_osc_en | input | 1 | secondary oscillator enabled |
| sleep_req | input | 1 | sleep request, one-cycle pulse |
| wake_req | input | 1 | wake request, one-cycle pulse |
| pri_tick | input | 1 | primary clock strobe |
| pri_rdy | input | 1 | primary clock ready |
| sec_tick | input | 1 | secondary clock strobe |
| sec_rdy | input | 1 | secondary oscillator ready |
| lf_tick | input | 1 | 31 kHz source strobe |
| int_rdy | input | 1 | internal block stable |
| cpu_tick | output | 1 | CPU clock enable |
| per_tick | output | 1 | peripheral clock enable |
| stat_pri | output | 1 | primary running |
| stat_int | output | 1 | internal block running and stable |
| stat_sec | output | 1 | secondary running |
| active_src | output | 2 | committed source |

## Verification
The bench targets five corner cases; each names the failure it would expose.

- A pending source write held for many cycles before sleep: a design that applies the select field at once would switch sources early.
- Every frequency code swept, with the tick period measured: a postscaler tap that is off by one would give periods that are doubled or halved.
- A switch to a secondary oscillator that is not yet ready: a design that skips the WAIT state would leak ticks before the oscillator is ready.
- The disabled-secondary rejection: a design without it would leave the system on a dead clock.
- Idle mode with the idle-enable bit set and clear: this shows whether the peripheral strobe is gated correctly.

// File: rtl/pmclk_pkg.sv
package pmclk_pkg;

    typedef enum logic [1:0] {
        SRC_PRI = 2'b00,
        SRC_SEC = 2'b01,
        SRC_INT = 2'b10
    } src_e;

    typedef enum logic [1:0] {
        ST_WAIT = 2'b00,
        ST_DROP = 2'b01,
        ST_RUN  = 2'b10
    } sw_state_e;

    function automatic src_e decode_sel(input logic [1:0] f);
        if (f[1])
            return SRC_INT;
        else if (f[0])
            return SRC_SEC;
        else
            return SRC_PRI;
    endfunction

endpackage

// File: rtl/pmclk_regs.sv
module pmclk_regs #(
    parameter int SEL_W  = 2,
    parameter int FREQ_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_src_i,
    input  logic [FREQ_W-1:0] wr_freq_i,
    input  logic              wr_idle_i,
    output logic [SEL_W-1:0]  src_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic              idle_o
);

    logic [SEL_W-1:0]  src_q;
    logic [FREQ_W-1:0] freq_q;
    logic              idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            freq_q <= '0;
            idle_q <= 1'b0;
        end else if (wr_en_i) begin
            src_q  <= wr_src_i;
            freq_q <= wr_freq_i;
            idle_q <= wr_idle_i;
        end
    end

    assign src_o  = src_q;
    assign freq_o = freq_q;
    assign idle_o = idle_q;

    // R1
    src_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (src_q == '0 && freq_q == '0));

endmodule

// File: rtl/pmclk_postscale.sv
module pmclk_postscale #(
    parameter int FREQ_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] freq_i,
    input  logic              lf_tick_i,
    output logic              tick_o
);

    localparam int CODES  = 1 << FREQ_W;
    localparam int STAGES = CODES - 2;

    logic [STAGES-1:0] cnt_q;
    logic [CODES-1:0]  tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tap[0]       = lf_tick_i;
    assign tap[CODES-1] = 1'b1;

    generate
        for (genvar g = 1; g <= STAGES; g++) begin : g_tap
            assign tap[g] = &cnt_q[STAGES-g:0];
        end
    endgenerate

    assign tick_o = tap[freq_i];

    // R5
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(tick_o)) |->
        (freq_i == '1 || freq_i == '0 || $past(freq_i) != freq_i));

endmodule

// File: rtl/pmclk_fsm.sv
module pmclk_fsm
    import pmclk_pkg::*;
#(
    parameter int FREQ_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req_i,
    input  logic              wake_req_i,
    input  logic [1:0]        src_sel_i,
    input  logic              sec_en_i,
    input  logic              idle_i,
    input  logic [FREQ_W-1:0] freq_i,
    input  logic              pri_rdy_i,
    input  logic              sec_rdy_i,
    input  logic              int_rdy_i,
    input  logic              pri_tick_i,
    input  logic              sec_tick_i,
    input  logic              int_tick_i,
    output logic              cpu_tick_o,
    output logic              per_tick_o,
    output logic              stat_pri_o,
    output logic              stat_int_o,
    output logic              stat_sec_o,
    output logic [1:0]        active_o
);

    sw_state_e state_q;
    src_e      active_q;
    src_e      want;
    src_e      tgt;
    logic      pm_q;
    logic      src_rdy;
    logic      src_tick;
    logic      running;

    always_comb begin
        want = decode_sel(src_sel_i);
        tgt  = (want == SRC_SEC && !sec_en_i) ? active_q : want;
        unique case (active_q)
            SRC_PRI: begin src_rdy = pri_rdy_i; src_tick = pri_tick_i; end
            SRC_SEC: begin src_rdy = sec_rdy_i; src_tick = sec_tick_i; end
            default: begin src_rdy = int_rdy_i; src_tick = int_tick_i; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_WAIT;
            active_q <= SRC_PRI;
        end else begin
            unique case (state_q)
                ST_WAIT: if (src_rdy) state_q <= ST_RUN;
                ST_DROP: state_q <= ST_WAIT;
                ST_RUN: begin
                    if (sleep_req_i && tgt != active_q) begin
                        active_q <= tgt;
                        state_q  <= ST_DROP;
                    end
                end
                default: state_q <= ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pm_q <= 1'b0;
        else if (sleep_req_i && state_q == ST_RUN)
            pm_q <= 1'b1;
        else if (wake_req_i)
            pm_q <= 1'b0;
    end

    always_comb begin
        running    = (state_q == ST_RUN);
        cpu_tick_o = running && src_tick && !pm_q;
        per_tick_o = running && src_tick && (!pm_q || idle_i);
        stat_pri_o = running && active_q == SRC_PRI && pri_rdy_i;
        stat_sec_o = running && active_q == SRC_SEC && sec_rdy_i;
        stat_int_o = running && active_q == SRC_INT && int_rdy_i && freq_i != '0;
        active_o   = active_q;
    end

    // R7
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_pri_o, stat_int_o, stat_sec_o}));

    // R3
    commit_on_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q != $past(active_q)) |-> ($past(sleep_req_i) && $past(state_q) == ST_RUN));

    // R4
    drop_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |=> (state_q == ST_WAIT && !per_tick_o));

    // R9
    sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req_i && !sec_en_i && src_sel_i == 2'b01)
        |=> (active_q == $past(active_q)));

endmodule

// File: rtl/pm_clk_ctrl.sv
module pm_clk_ctrl #(
    parameter int FREQ_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_src,
    input  logic [FREQ_W-1:0] wr_freq,
    input  logic              wr_idle,
    input  logic              sec_osc_en,
    input  logic              sleep_req,
    input  logic              wake_req,
    input  logic              pri_tick,
    input  logic              pri_rdy,
    input  logic              sec_tick,
    input  logic              sec_rdy,
    input  logic              lf_tick,
    input  logic              int_rdy,
    output logic              cpu_tick,
    output logic              per_tick,
    output logic              stat_pri,
    output logic              stat_int,
    output logic              stat_sec,
    output logic [1:0]        active_src
);

    logic [1:0]        src_sel;
    logic [FREQ_W-1:0] freq_sel;
    logic              idle_en;
    logic              int_tick;
    logic              int_ready;

    pmclk_regs #(.SEL_W(2), .FREQ_W(FREQ_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_src_i  (wr_src),
        .wr_freq_i (wr_freq),
        .wr_idle_i (wr_idle),
        .src_o     (src_sel),
        .freq_o    (freq_sel),
        .idle_o    (idle_en)
    );

    pmclk_postscale #(.FREQ_W(FREQ_W)) u_post (
        .clk       (clk),
        .rst_n     (rst_n),
        .freq_i    (freq_sel),
        .lf_tick_i (lf_tick),
        .tick_o    (int_tick)
    );

    assign int_ready = (freq_sel == '0) || int_rdy;

    pmclk_fsm #(.FREQ_W(FREQ_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_i (sleep_req),
        .wake_req_i  (wake_req),
        .src_sel_i   (src_sel),
        .sec_en_i    (sec_osc_en),
        .idle_i      (idle_en),
        .freq_i      (freq_sel),
        .pri_rdy_i   (pri_rdy),
        .sec_rdy_i   (sec_rdy),
        .int_rdy_i   (int_ready),
        .pri_tick_i  (pri_tick),
        .sec_tick_i  (sec_tick),
        .int_tick_i  (int_tick),
        .cpu_tick_o  (cpu_tick),
        .per_tick_o  (per_tick),
        .stat_pri_o  (stat_pri),
        .stat_int_o  (stat_int),
        .stat_sec_o  (stat_sec),
        .active_o    (active_src)
    );

endmodule

// File: tb/pm_clk_ctrl_test.sv
module pm_clk_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_src = 2'b00;
    logic [2:0] wr_freq = 3'b000;
    logic       wr_idle = 1'b0;
    logic       sec_osc_en = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       pri_tick = 1'b0;
    logic       pri_rdy = 1'b1;
    logic       sec_tick = 1'b0;
    logic       sec_rdy = 1'b0;
    logic       lf_tick = 1'b0;
    logic       int_rdy = 1'b1;
    logic       cpu_tick, per_tick, stat_pri, stat_int, stat_sec;
    logic [1:0] active_src;

    int total = 0;
    int bad = 0;
    int excl_viol = 0;
    int cyc = 0;
    int pc = 0, sc = 0, lc = 0;

    pm_clk_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_src(wr_src),
        .wr_freq(wr_freq), .wr_idle(wr_idle), .sec_osc_en(sec_osc_en),
        .sleep_req(sleep_req), .wake_req(wake_req), .pri_tick(pri_tick),
        .pri_rdy(pri_rdy), .sec_tick(sec_tick), .sec_rdy(sec_rdy),
        .lf_tick(lf_tick), .int_rdy(int_rdy), .cpu_tick(cpu_tick),
        .per_tick(per_tick), .stat_pri(stat_pri), .stat_int(stat_int),
        .stat_sec(stat_sec), .active_src(active_src)
    );

    always #5 clk = ~clk;

    // source strobes: primary every 3, secondary every 5, low-power every 40
    always @(negedge clk) begin
        pc <= (pc == 2) ? 0 : pc + 1;
        sc <= (sc == 4) ? 0 : sc + 1;
        lc <= (lc == 39) ? 0 : lc + 1;
        pri_tick <= (pc == 2);
        sec_tick <= (sc == 4);
        lf_tick  <= (lc == 39);
    end

    // R7 monitor: status bits never overlap
    always @(negedge clk) begin
        if (rst_n && (int'(stat_pri) + int'(stat_int) + int'(stat_sec)) > 1)
            excl_viol++;
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [1:0] s, input logic [2:0] f, input logic i);
        wr_en = 1'b1; wr_src = s; wr_freq = f; wr_idle = i;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1; step(1); wake_req = 1'b0;
    endtask

    // period between two consecutive ticks (sel 0 = cpu, 1 = per); -1 on timeout
    task automatic measure(input bit sel, output int per);
        int n;
        per = -1;
        n = 0;
        while (!(sel ? per_tick : cpu_tick) && n < 500) begin step(1); n++; end
        if (n >= 500) return;
        n = 0;
        do begin step(1); n++; end while (!(sel ? per_tick : cpu_tick) && n < 500);
        if (n < 500) per = n;
    endtask

    task automatic count_ticks(input int cycles, output int nc, output int np);
        nc = 0; np = 0;
        for (int i = 0; i < cycles; i++) begin
            if (cpu_tick) nc++;
            if (per_tick) np++;
            step(1);
        end
    endtask

    initial begin
        int p, nc, np;
        step(5);
        rst_n = 1'b1;
        step(3);

        // R1 reset state
        chk(active_src == 2'b00, "R1 active after reset", active_src, 0);
        chk(stat_pri == 1'b1, "R1 primary running", stat_pri, 1);
        // R2 primary drives the ticks
        measure(0, p);
        chk(p == 3, "R2 primary period", p, 3);

        // R3 pending select held without sleep
        write(2'b10, 3'b000, 1'b0);
        step(12);
        chk(active_src == 2'b00, "R3 pending select ignored", active_src, 0);
        chk(stat_pri == 1'b1 && stat_int == 1'b0, "R3 status unchanged", stat_pri, 1);
        measure(0, p);
        chk(p == 3, "R3 ticks still primary", p, 3);

        // R2 commit on sleep to internal (31 kHz)
        pulse_sleep();
        chk(active_src == 2'b10, "R2 internal committed", active_src, 2);
        pulse_wake();
        step(2);
        measure(0, p);
        chk(p == 40, "R5 code 000 follows lf_tick", p, 40);
        chk({stat_pri, stat_int, stat_sec} == 3'b000, "R8 lf source status clear",
            {stat_pri, stat_int, stat_sec}, 0);

        // R5/R6 sweep of postscaled codes, rate change without sleep
        for (int code = 7; code >= 1; code--) begin
            write(2'b10, 3'(code), 1'b0);
            measure(0, p);
            chk(p == (1 << (7 - code)), $sformatf("R6 R5 code %0d period", code),
                p, 1 << (7 - code));
            chk(stat_int == 1'b1 && stat_pri == 1'b0 && stat_sec == 1'b0,
                $sformatf("R7 status code %0d", code), {stat_pri, stat_int, stat_sec}, 2);
        end

        // R8 internal not stable
        write(2'b10, 3'b011, 1'b0);
        int_rdy = 1'b0;
        step(2);
        chk({stat_pri, stat_int, stat_sec} == 3'b000, "R8 unstable status clear",
            {stat_pri, stat_int, stat_sec}, 0);
        int_rdy = 1'b1;
        step(2);

        // R9 secondary disabled: keep internal
        write(2'b01, 3'b011, 1'b0);
        sec_osc_en = 1'b0;
        pulse_sleep();
        step(4);
        chk(active_src == 2'b10, "R9 secondary rejected", active_src, 2);
        count_ticks(40, nc, np);
        chk(np == 0 && nc == 0, "R10 idle clear stops all", np, 0);
        pulse_wake();
        step(1);
        measure(0, p);
        chk(p == 16, "R10 wake restores cpu", p, 16);

        // R10 idle set: peripherals keep running
        write(2'b10, 3'b011, 1'b1);
        pulse_sleep();
        count_ticks(64, nc, np);
        chk(nc == 0, "R10 cpu stopped in idle", nc, 0);
        chk(np == 4, "R10 per running in idle", np, 4);
        pulse_wake();

        // R4 switch to secondary not yet ready
        write(2'b01, 3'b011, 1'b1);
        sec_osc_en = 1'b1;
        sec_rdy = 1'b0;
        pulse_sleep();
        chk(active_src == 2'b01, "R4 secondary committed", active_src, 1);
        count_ticks(30, nc, np);
        chk(np == 0, "R4 no ticks while waiting", np, 0);
        chk({stat_pri, stat_int, stat_sec} == 3'b000, "R4 status clear in wait",
            {stat_pri, stat_int, stat_sec}, 0);
        sec_rdy = 1'b1;
        step(3);
        chk(stat_sec == 1'b1, "R7 secondary running", stat_sec, 1);
        measure(1, p);
        chk(p == 5, "R4 secondary period", p, 5);
        pulse_wake();

        chk(excl_viol == 0, "R7 status overlap count", excl_viol, 0);
        finish_run();
    end

endmodule